// File: doc/BRIEF.md
# Paged Memory Allocator and Translator

This block manages one shared RAM bank on behalf of several hardware tasks. The bank is cut into a fixed number of equal pages whose size is a power of two. Each task sees its own virtual space that starts at address zero. A per-task page table maps the task's virtual page index onto a physical page, and the byte offset inside the page passes straight through.

Tasks grow or shrink their space at runtime with an allocate strobe or a free strobe. Free pages are kept on a stack, and each task's row of the page table is a stack as well. An allocation moves the top free page onto the task's row. A release moves the task's newest page back onto the free stack. Each of these operations takes a single clock edge. Translation runs on every cycle with the task ID and virtual address at the inputs, and its result is registered.

When allocate and free arrive together, the release is served first and the allocation follows on the next edge.

Top module: `paged_mmu`

## Requirements
- R1: During and right after reset, all response flags are 0, every task row is empty, and the free stack holds every page, so that the first allocations hand out page IDs 0, 1, 2, ... in ascending order.
- R2: One edge after `tid_i`/`vaddr_i` are applied, `paddr_o` equals {page ID stored at row `tid_i`, slot vaddr_i[VA_W-1:OFF_W]} concatenated with vaddr_i[OFF_W-1:0], where OFF_W = log2(page size).
- R3: If the virtual page index is not below the task's current page count, `xlat_fault_o` is 1 and `paddr_o` is 0 one edge later.
- R4: An accepted allocation pops the top of the free stack onto the top of the task's row and sets `alloc_ok_o` for one cycle. The new page becomes the task's highest virtual page.
- R5: An accepted release moves the task's highest page onto the free stack and sets `free_ok_o`. The next accepted allocation, for any task, receives that same page (last in, first out).
- R6: An allocation while the free stack is empty sets `alloc_err_o` and changes no state.
- R7: An allocation for a task whose row already holds MAX_ROW pages sets `alloc_err_o` and changes no state.
- R8: A release for a task with no pages sets `free_err_o` and changes no state.
- R9: When `alloc_i` and `free_i` are both high, the release for `tid_i` is handled on that edge, and the allocation for the same task is handled on the following edge.
- R10: On the edge where such a deferred allocation is handled, the strobes present at the inputs are ignored and produce no flag and no state change.
- R11: Translation uses the table state from before the current edge's operation, so a page allocated on an edge is not visible to the translation sampled on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tid_i | input | TASK_W | Task ID for translation and for allocate/free |
| vaddr_i | input | VA_W | Virtual address of the task |
| alloc_i | input | 1 | Request one new page for `tid_i` |
| free_i | input | 1 | Release the newest page of `tid_i` |
| paddr_o | output | PA_W | Registered physical address |
| xlat_fault_o | output | 1 | Registered invalid-access flag |
| alloc_ok_o | output | 1 | Allocation accepted on the last edge |
| alloc_err_o | output | 1 | Allocation refused on the last edge |
| free_ok_o | output | 1 | Release accepted on the last edge |
| free_err_o | output | 1 | Release refused on the last edge |

## Verification
The two operations that can collide are an allocation and a release on the same edge. Translation also runs alongside both. The bench raises both strobes for one task, then drives a second pair of strobes for another task on the next cycle. A reference model expects a release flag first, then an allocation flag for the original task, and no trace of the second pair. Translation is checked on the same edges against the pre-operation table, including a lookup of a page that is allocated on that very edge.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ALLOC = 2'd1,
    OP_FREE  = 2'd2
  } mmu_op_e;
endpackage

// File: rtl/mmu_free_stack.sv
module mmu_free_stack #(
  parameter int NUM_PAGES = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             push_i,
  input  logic [$clog2(NUM_PAGES)-1:0]     push_id_i,
  input  logic                             pop_i,
  output logic [$clog2(NUM_PAGES)-1:0]     top_id_o,
  output logic [$clog2(NUM_PAGES+1)-1:0]   count_o
);
  localparam int PID_W = $clog2(NUM_PAGES);
  localparam int CNT_W = $clog2(NUM_PAGES + 1);

  logic [PID_W-1:0] slots [NUM_PAGES];
  logic [CNT_W-1:0] depth;
  logic [CNT_W-1:0] top_idx;

  assign top_idx  = depth - 1'b1;
  assign top_id_o = slots[top_idx[PID_W-1:0]];
  assign count_o  = depth;

  // reset fills the stack so that page 0 sits on top
  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= CNT_W'(NUM_PAGES);
      for (int i = 0; i < NUM_PAGES; i++) begin
        slots[i] <= PID_W'(NUM_PAGES - 1 - i);
      end
    end else if (push_i) begin
      slots[depth[PID_W-1:0]] <= push_id_i;
      depth <= depth + 1'b1;
    end else if (pop_i) begin
      depth <= depth - 1'b1;
    end
  end
endmodule

// File: rtl/mmu_page_rows.sv
module mmu_page_rows #(
  parameter int NUM_TASKS = 4,
  parameter int NUM_PAGES = 8,
  parameter int MAX_ROW   = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push_i,
  input  logic                           pop_i,
  input  logic [$clog2(NUM_TASKS)-1:0]   tid_i,
  input  logic [$clog2(NUM_PAGES)-1:0]   push_id_i,
  output logic [$clog2(NUM_PAGES)-1:0]   top_id_o,
  output logic [$clog2(MAX_ROW+1)-1:0]   cnt_o,
  input  logic [$clog2(NUM_TASKS)-1:0]   x_tid_i,
  input  logic [$clog2(MAX_ROW)-1:0]     x_slot_i,
  output logic [$clog2(NUM_PAGES)-1:0]   x_id_o,
  output logic [$clog2(MAX_ROW+1)-1:0]   x_cnt_o
);
  localparam int TASK_W = $clog2(NUM_TASKS);
  localparam int SLOT_W = $clog2(MAX_ROW);
  localparam int RC_W   = $clog2(MAX_ROW + 1);
  localparam int PID_W  = $clog2(NUM_PAGES);
  localparam int ENTRIES = NUM_TASKS * MAX_ROW;

  logic [PID_W-1:0] table_q [ENTRIES];
  logic [RC_W-1:0]  fill    [NUM_TASKS];
  logic [RC_W-1:0]  top_slot;
  logic [TASK_W+SLOT_W-1:0] wr_idx, top_idx, x_idx;

  assign cnt_o    = fill[tid_i];
  assign top_slot = cnt_o - 1'b1;
  assign wr_idx   = {tid_i, cnt_o[SLOT_W-1:0]};
  assign top_idx  = {tid_i, top_slot[SLOT_W-1:0]};
  assign x_idx    = {x_tid_i, x_slot_i};
  assign top_id_o = table_q[top_idx];
  assign x_id_o   = table_q[x_idx];
  assign x_cnt_o  = fill[x_tid_i];

  // table contents carry no reset; validity comes from the fill counters
  always_ff @(posedge clk) begin
    if (push_i) begin
      table_q[wr_idx] <= push_id_i;
    end
  end

  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_fill
    always_ff @(posedge clk) begin
      if (rst) begin
        fill[g] <= '0;
      end else if (tid_i == TASK_W'(g)) begin
        if (push_i) begin
          fill[g] <= fill[g] + 1'b1;
        end else if (pop_i) begin
          fill[g] <= fill[g] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/paged_mmu.sv
module paged_mmu
  import mmu_pkg::*;
#(
  parameter int NUM_TASKS  = 4,
  parameter int NUM_PAGES  = 8,
  parameter int MAX_ROW    = 4,
  parameter int PAGE_WORDS = 16,
  localparam int TASK_W = $clog2(NUM_TASKS),
  localparam int OFF_W  = $clog2(PAGE_WORDS),
  localparam int VA_W   = $clog2(MAX_ROW) + OFF_W,
  localparam int PA_W   = $clog2(NUM_PAGES) + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TASK_W-1:0] tid_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              alloc_i,
  input  logic              free_i,
  output logic [PA_W-1:0]   paddr_o,
  output logic              xlat_fault_o,
  output logic              alloc_ok_o,
  output logic              alloc_err_o,
  output logic              free_ok_o,
  output logic              free_err_o
);
  localparam int PID_W  = $clog2(NUM_PAGES);
  localparam int SLOT_W = $clog2(MAX_ROW);
  localparam int RC_W   = $clog2(MAX_ROW + 1);
  localparam int FC_W   = $clog2(NUM_PAGES + 1);

  logic              defer_q;
  logic [TASK_W-1:0] defer_tid_q;
  mmu_op_e           op;
  logic [TASK_W-1:0] op_tid;
  logic              alloc_go, free_go, defer_set;

  logic [PID_W-1:0]  free_top, row_top, x_id;
  logic [FC_W-1:0]   free_cnt;
  logic [RC_W-1:0]   row_cnt, x_cnt;
  logic [SLOT_W-1:0] vslot;
  logic [OFF_W-1:0]  voff;
  logic              x_hit;

  // pick this edge's operation: deferred allocation, then release, then allocation
  always_comb begin
    op_tid = defer_q ? defer_tid_q : tid_i;
    if (defer_q) begin
      op = OP_ALLOC;
    end else if (free_i) begin
      op = OP_FREE;
    end else if (alloc_i) begin
      op = OP_ALLOC;
    end else begin
      op = OP_NONE;
    end
  end

  assign alloc_go  = (op == OP_ALLOC) && (free_cnt != '0) && (row_cnt != RC_W'(MAX_ROW));
  assign free_go   = (op == OP_FREE) && (row_cnt != '0);
  assign defer_set = !defer_q && free_i && alloc_i;

  mmu_free_stack #(.NUM_PAGES(NUM_PAGES)) u_free (
    .clk       (clk),
    .rst       (rst),
    .push_i    (free_go),
    .push_id_i (row_top),
    .pop_i     (alloc_go),
    .top_id_o  (free_top),
    .count_o   (free_cnt)
  );

  assign vslot = vaddr_i[VA_W-1:OFF_W];
  assign voff  = vaddr_i[OFF_W-1:0];

  mmu_page_rows #(
    .NUM_TASKS (NUM_TASKS),
    .NUM_PAGES (NUM_PAGES),
    .MAX_ROW   (MAX_ROW)
  ) u_rows (
    .clk       (clk),
    .rst       (rst),
    .push_i    (alloc_go),
    .pop_i     (free_go),
    .tid_i     (op_tid),
    .push_id_i (free_top),
    .top_id_o  (row_top),
    .cnt_o     (row_cnt),
    .x_tid_i   (tid_i),
    .x_slot_i  (vslot),
    .x_id_o    (x_id),
    .x_cnt_o   (x_cnt)
  );

  assign x_hit = RC_W'(vslot) < x_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      defer_q      <= 1'b0;
      defer_tid_q  <= '0;
      paddr_o      <= '0;
      xlat_fault_o <= 1'b0;
      alloc_ok_o   <= 1'b0;
      alloc_err_o  <= 1'b0;
      free_ok_o    <= 1'b0;
      free_err_o   <= 1'b0;
    end else begin
      defer_q      <= defer_set;
      if (defer_set) begin
        defer_tid_q <= tid_i;
      end
      paddr_o      <= x_hit ? {x_id, voff} : '0;
      xlat_fault_o <= !x_hit;
      alloc_ok_o   <= alloc_go;
      alloc_err_o  <= (op == OP_ALLOC) && !alloc_go;
      free_ok_o    <= free_go;
      free_err_o   <= (op == OP_FREE) && !free_go;
    end
  end
endmodule

// File: rtl/paged_mmu_chk.sv
module paged_mmu_chk #(
  parameter int PA_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            alloc_i,
  input logic            free_i,
  input logic [PA_W-1:0] paddr_o,
  input logic            xlat_fault_o,
  input logic            alloc_ok_o,
  input logic            alloc_err_o,
  input logic            free_ok_o,
  input logic            free_err_o
);
  logic pend;

  // independent tracker of the cycle after a collision
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= alloc_i && free_i && !pend;
  end

  assert_alloc_flags_R4: assert property (@(posedge clk) disable iff (rst)
    !(alloc_ok_o && alloc_err_o));

  assert_free_flags_R8: assert property (@(posedge clk) disable iff (rst)
    !(free_ok_o && free_err_o));

  assert_fault_zero_R3: assert property (@(posedge clk) disable iff (rst)
    xlat_fault_o |-> (paddr_o == '0));

  assert_alloc_answer_R6: assert property (@(posedge clk) disable iff (rst)
    (alloc_i && !free_i && !pend) |=> (alloc_ok_o || alloc_err_o));

  assert_free_answer_R5: assert property (@(posedge clk) disable iff (rst)
    (free_i && !pend) |=> ((free_ok_o || free_err_o) && !alloc_ok_o && !alloc_err_o));

  assert_collide_order_R9: assert property (@(posedge clk) disable iff (rst)
    (alloc_i && free_i && !pend) |=> (free_ok_o || free_err_o) ##1 (alloc_ok_o || alloc_err_o));

  assert_defer_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    pend |=> (!free_ok_o && !free_err_o));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!alloc_i && !free_i && !pend) |=> !(alloc_ok_o || alloc_err_o || free_ok_o || free_err_o));
endmodule

bind paged_mmu paged_mmu_chk #(.PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .alloc_i      (alloc_i),
  .free_i       (free_i),
  .paddr_o      (paddr_o),
  .xlat_fault_o (xlat_fault_o),
  .alloc_ok_o   (alloc_ok_o),
  .alloc_err_o  (alloc_err_o),
  .free_ok_o    (free_ok_o),
  .free_err_o   (free_err_o)
);

// File: tb/test_paged_mmu.sv
`timescale 1ns/1ps
module test_paged_mmu;
  localparam int T    = 4;
  localparam int N    = 8;
  localparam int M    = 4;
  localparam int PG   = 16;
  localparam int TW   = 2;
  localparam int VAW  = 6;
  localparam int PAW  = 7;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [TW-1:0]  tid_i = '0;
  logic [VAW-1:0] vaddr_i = '0;
  logic           alloc_i = 1'b0;
  logic           free_i = 1'b0;
  logic [PAW-1:0] paddr_o;
  logic           xlat_fault_o, alloc_ok_o, alloc_err_o, free_ok_o, free_err_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  paged_mmu i_paged_mmu (
    .clk(clk), .rst(rst), .tid_i(tid_i), .vaddr_i(vaddr_i),
    .alloc_i(alloc_i), .free_i(free_i), .paddr_o(paddr_o),
    .xlat_fault_o(xlat_fault_o), .alloc_ok_o(alloc_ok_o), .alloc_err_o(alloc_err_o),
    .free_ok_o(free_ok_o), .free_err_o(free_err_o)
  );

  // reference model
  int m_free [N];
  int m_fcnt;
  int m_row  [T][M];
  int m_cnt  [T];
  bit m_def;
  int m_dtid;

  task automatic model_reset();
    m_fcnt = N;
    for (int i = 0; i < N; i++) m_free[i] = N - 1 - i;
    for (int i = 0; i < T; i++) m_cnt[i] = 0;
    m_def = 1'b0;
    m_dtid = 0;
  endtask

  task automatic check(input string what, input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", what, tag, act, exp);
    end
  endtask

  // drive at a falling edge, predict, then compare at the next falling edge
  task automatic step(input bit a, input bit f, input int t, input int va, input string tag);
    int vpn, off, ot, e_pa;
    bit e_fault, is_a, is_f, e_ga, e_da, e_fo, e_fe, nd;
    alloc_i = a; free_i = f; tid_i = TW'(t); vaddr_i = VAW'(va);
    vpn = va / PG; off = va % PG;
    e_fault = (vpn >= m_cnt[t]);
    e_pa = e_fault ? 0 : m_row[t][vpn] * PG + off;
    ot   = m_def ? m_dtid : t;
    is_a = m_def || (a && !f);
    is_f = !m_def && f;
    e_ga = is_a && (m_fcnt > 0) && (m_cnt[ot] < M);
    e_da = is_a && !e_ga;
    e_fo = is_f && (m_cnt[ot] > 0);
    e_fe = is_f && !e_fo;
    nd   = !m_def && a && f;
    if (e_fo) begin
      m_cnt[ot]--;
      m_free[m_fcnt] = m_row[ot][m_cnt[ot]];
      m_fcnt++;
    end
    if (e_ga) begin
      m_fcnt--;
      m_row[ot][m_cnt[ot]] = m_free[m_fcnt];
      m_cnt[ot]++;
    end
    if (nd) m_dtid = t;
    m_def = nd;
    @(negedge clk);
    check("alloc_ok R4", tag, int'(alloc_ok_o), int'(e_ga));
    check("alloc_err R6 R7", tag, int'(alloc_err_o), int'(e_da));
    check("free_ok R5", tag, int'(free_ok_o), int'(e_fo));
    check("free_err R8", tag, int'(free_err_o), int'(e_fe));
    check("fault R3", tag, int'(xlat_fault_o), int'(e_fault));
    check("paddr R2", tag, int'(paddr_o), e_pa);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    check("reset flags R1", "R1",
          int'({alloc_ok_o, alloc_err_o, free_ok_o, free_err_o, xlat_fault_o}), 0);
    check("reset paddr R1", "R1", int'(paddr_o), 0);
    rst = 1'b0;
    step(0, 0, 0, 0, "R1");                     // empty row faults
    for (int i = 0; i < M; i++) step(1, 0, 0, 0, "R1");   // pages 0..3 in order
    step(0, 0, 0, 3 * PG + 9, "R2");            // page 3 slot 3
    step(0, 0, 0, 1 * PG + 15, "R2");
    step(1, 0, 0, 0, "R7");                     // row full
    for (int i = 0; i < M; i++) step(1, 0, 1, 0, "R4");   // pages 4..7
    step(0, 0, 1, 2 * PG + 4, "R2");
    step(1, 0, 2, 0, "R6");                     // free stack empty
    step(0, 1, 2, 0, "R8");                     // release of empty row
    step(0, 1, 0, 3 * PG, "R5");
    step(1, 0, 2, 0, "R5");                     // receives page 3 back
    step(0, 0, 2, 7, "R5");
    step(0, 1, 1, 0, "R5");                     // frees page 7
    step(1, 0, 3, 0, "R11");                    // same-edge lookup still faults
    step(0, 0, 3, 5, "R11");
    step(1, 1, 1, 0, "R9");                     // release first
    step(1, 1, 0, 0, "R10");                    // deferred alloc for task 1; these strobes ignored
    step(0, 0, 1, 2 * PG + 1, "R9");
    step(0, 0, 0, 3 * PG, "R10");               // task 0 untouched
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, ($urandom % 4) == 0, int'($urandom % T),
           int'($urandom % (M * PG)), "RND");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule